// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block sits between a host bus master and the local RAM of an I/O coprocessor. The host never addresses that RAM directly. Instead it loads a 16-bit pointer one byte at a time, through a high-byte register and a low-byte register. It then moves bytes through a single data window. When the step-after-access option is on, the pointer advances by one after every window access. This lets a host stream a block of bytes with back-to-back window accesses.

The same register file holds one status/control byte. That byte carries the following:
- a run bit whose cleared state holds the coprocessor in reset;
- a sticky interrupt request toward the coprocessor;
- two interrupt priority flags raised by the coprocessor toward the host, each cleared by writing one;
- a bypass select;
- two read-only hardware flags that only report while bypass is selected.

Address bit 0 is not decoded, so every register answers at an even offset and at the odd offset just above it. The RAM sits outside the block on a single-port byte interface with combinational read data.

Top module: `shram_host_port`

## Requirements
- R1: Register selection uses the host address with bit 0 ignored. The pointer high byte is at 0/1, the pointer low byte at 2/3, status/control at 4/5 and the data window at 8/9.
- R2: Writing the high or low register loads that byte of the 16-bit pointer. Reading either register returns that byte. `ram_addr` always equals the pointer.
- R3: A host write to the data window pulses `ram_we` for one cycle, with `ram_addr` at the pointer and `ram_wdata` equal to the written byte. A host read of the window returns `ram_rdata` in the same cycle and pulses `ram_re`.
- R4: With status/control bit 1 set, every data window access, read or write, advances the pointer by one after the access. With bit 1 clear, the pointer is unchanged by window accesses.
- R5: The pointer advances from 0xFFFF to 0x0000.
- R6: Status/control bit 2 is the run bit and drives `cop_run`. Writing 0 to it holds the coprocessor in reset.
- R7: Writing 1 to status/control bit 3 sets the coprocessor interrupt `cop_irq`. Writing 0 to bit 3 has no effect. `cop_irq` stays set until a `cop_irq_ack` pulse clears it, and a host set in the same cycle as an ack wins.
- R8: A pulse on `cop_int[0]` or `cop_int[1]` sets status/control bit 4 or bit 5. Writing 1 to either bit clears it, and a set in the same cycle as a clear wins. `host_irq` is high while either bit is set.
- R9: Bit 0 is the bypass select and drives `bypass`. Bit 6 reads `hw_int` and bit 7 reads the inverse of `dma_req`, both only while bypass is set, and read 0 otherwise. Writes to bits 6 and 7 have no effect.
- R10: Accesses at unmapped offsets read 0x00 and change no state.
- R11: After reset the pointer is 0x0000 and status/control reads 0x00. `cop_run`, `cop_irq`, `host_irq` and `bypass` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (4) | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the access cycle |
| ram_addr | output | 16 | Shared RAM address (the pointer) |
| ram_wdata | output | 8 | Shared RAM write data |
| ram_we | output | 1 | Shared RAM write strobe |
| ram_re | output | 1 | Shared RAM read strobe |
| ram_rdata | input | 8 | Shared RAM read data (combinational) |
| cop_run | output | 1 | Coprocessor run; low holds it in reset |
| cop_irq | output | 1 | Interrupt request toward the coprocessor |
| cop_irq_ack | input | 1 | Coprocessor acknowledge, clears `cop_irq` |
| cop_int | input | 2 | Coprocessor-to-host priority interrupt set pulses |
| hw_int | input | 1 | Hardware interrupt level, reported in bypass |
| dma_req | input | 1 | DMA request level, inverse reported in bypass |
| bypass | output | 1 | Bypass select |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
The pointer is tried with window writes and reads in both step modes. Reading the low byte back after two window accesses tells advance from hold, and re-reading from a reloaded pointer tells whether the bytes landed at consecutive addresses. The register aliases are exercised by alternating even and odd offsets. The wrap case uses a window write at 0xFFFF followed by a pointer readback. The control byte is driven with same-cycle set-and-clear collisions, to tell set-wins from clear-wins. The bypass-only flags are read with bypass on and off under identical input levels.

// File: rtl/shram_pkg.sv
package shram_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PTR_HI,
        SEL_PTR_LO,
        SEL_CTRL,
        SEL_DATA
    } reg_sel_e;

    // even byte offsets of the registers (bit 0 is never decoded)
    localparam int unsigned OFS_PTR_HI = 0;
    localparam int unsigned OFS_PTR_LO = 2;
    localparam int unsigned OFS_CTRL   = 4;
    localparam int unsigned OFS_DATA   = 8;

    // status/control bit positions
    localparam int unsigned CB_BYPASS  = 0;
    localparam int unsigned CB_STEP    = 1;
    localparam int unsigned CB_RUN     = 2;
    localparam int unsigned CB_IRQ     = 3;
    localparam int unsigned CB_PRI_LO  = 4;
    localparam int unsigned CB_PRI_HI  = 5;
    localparam int unsigned CB_HWINT   = 6;
    localparam int unsigned CB_NODMA   = 7;

    localparam int unsigned PRI_LINES  = 2;

    typedef struct packed {
        logic                 bypass;
        logic                 step;
        logic                 run;
        logic                 irq;
        logic [PRI_LINES-1:0] pri;
    } ctrl_state_t;

endpackage

// File: rtl/shram_decode.sv
module shram_decode
    import shram_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] host_addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

    logic [ADDR_W-1:0] aligned;

    always_comb begin
        aligned = host_addr & EVEN_MASK;
        if (aligned == ADDR_W'(OFS_PTR_HI))      sel = SEL_PTR_HI;
        else if (aligned == ADDR_W'(OFS_PTR_LO)) sel = SEL_PTR_LO;
        else if (aligned == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
        else if (aligned == ADDR_W'(OFS_DATA))   sel = SEL_DATA;
        else                                     sel = SEL_NONE;
    end
endmodule

// File: rtl/shram_ptr.sv
module shram_ptr #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr
);
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ld_hi) begin
            ptr_d.hi = wdata;
        end else if (ld_lo) begin
            ptr_d.lo = wdata;
        end else if (step) begin
            // natural modulo wrap of the full pointer
            ptr_d = ptr_t'(PTR_W'(ptr_q) + PTR_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
    import shram_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PRI_LINES-1:0] pri_set,
    input  logic                 irq_ack,
    input  logic                 hw_int,
    input  logic                 dma_req,
    output ctrl_state_t          state,
    output logic [DATA_W-1:0]    status
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_ack) st_d.irq = 1'b0;
        if (wr_en) begin
            st_d.bypass = wdata[CB_BYPASS];
            st_d.step   = wdata[CB_STEP];
            st_d.run    = wdata[CB_RUN];
            if (wdata[CB_IRQ]) st_d.irq = 1'b1;
            st_d.pri    = st_q.pri & ~wdata[CB_PRI_HI:CB_PRI_LO];
        end
        st_d.pri = st_d.pri | pri_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status                        = '0;
        status[CB_BYPASS]             = st_q.bypass;
        status[CB_STEP]               = st_q.step;
        status[CB_RUN]                = st_q.run;
        status[CB_IRQ]                = st_q.irq;
        status[CB_PRI_HI:CB_PRI_LO]   = st_q.pri;
        status[CB_HWINT]              = st_q.bypass & hw_int;
        status[CB_NODMA]              = st_q.bypass & ~dma_req;
    end

    assign state = st_q;
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
    import shram_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_sel,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [PTR_W-1:0]     ram_addr,
    output logic [DATA_W-1:0]    ram_wdata,
    output logic                 ram_we,
    output logic                 ram_re,
    input  logic [DATA_W-1:0]    ram_rdata,
    output logic                 cop_run,
    output logic                 cop_irq,
    input  logic                 cop_irq_ack,
    input  logic [PRI_LINES-1:0] cop_int,
    input  logic                 hw_int,
    input  logic                 dma_req,
    output logic                 bypass,
    output logic                 host_irq
);
    reg_sel_e          sel;
    ctrl_state_t       ctrl_q;
    logic [DATA_W-1:0] status;
    logic [PTR_W-1:0]  ptr;
    logic              wr_acc;
    logic              win_acc;
    logic              step_on;

    shram_decode #(.ADDR_W(ADDR_W)) u_dec (
        .host_addr (host_addr),
        .sel       (sel)
    );

    always_comb begin
        wr_acc  = host_sel & host_we;
        win_acc = host_sel & (sel == SEL_DATA);
    end

    shram_ptr #(.DATA_W(DATA_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (wr_acc & (sel == SEL_PTR_HI)),
        .ld_lo (wr_acc & (sel == SEL_PTR_LO)),
        .step  (win_acc & step_on),
        .wdata (host_wdata),
        .ptr   (ptr)
    );

    shram_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc & (sel == SEL_CTRL)),
        .wdata   (host_wdata),
        .pri_set (cop_int),
        .irq_ack (cop_irq_ack),
        .hw_int  (hw_int),
        .dma_req (dma_req),
        .state   (ctrl_q),
        .status  (status)
    );

    assign step_on = ctrl_q.step;

    always_comb begin
        unique case (sel)
            SEL_PTR_HI: host_rdata = ptr[PTR_W-1:DATA_W];
            SEL_PTR_LO: host_rdata = ptr[DATA_W-1:0];
            SEL_CTRL:   host_rdata = status;
            SEL_DATA:   host_rdata = ram_rdata;
            default:    host_rdata = '0;
        endcase
    end

    assign ram_addr  = ptr;
    assign ram_wdata = host_wdata;
    assign ram_we    = win_acc & host_we;
    assign ram_re    = win_acc & ~host_we;
    assign cop_run   = ctrl_q.run;
    assign cop_irq   = ctrl_q.irq;
    assign bypass    = ctrl_q.bypass;
    assign host_irq  = |ctrl_q.pri;
endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PTR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [PTR_W-1:0]  ram_addr,
    input logic              ram_we,
    input logic              step_on,
    input logic              cop_run,
    input logic              cop_irq,
    input logic              cop_irq_ack,
    input logic [1:0]        cop_int,
    input logic              host_irq
);
    logic win_hit, ctrl_wr;
    assign win_hit = host_sel && ((host_addr >> 1) == ADDR_W'(4));
    assign ctrl_wr = host_sel && host_we && ((host_addr >> 1) == ADDR_W'(2));

    a_r3_we_only_window: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (win_hit && host_we));

    a_r4_step_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && step_on) |=> ram_addr == PTR_W'($past(ram_addr) + 1'b1));

    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !step_on) |=> $stable(ram_addr));

    a_r6_run_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cop_run));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_irq && !cop_irq_ack) |=> cop_irq);

    a_r8_pri_raises_host: assert property (@(posedge clk) disable iff (!rst_n)
        (|cop_int) |=> host_irq);
endmodule

bind shram_host_port shram_host_port_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .step_on     (step_on),
    .cop_run     (cop_run),
    .cop_irq     (cop_irq),
    .cop_irq_ack (cop_irq_ack),
    .cop_int     (cop_int),
    .host_irq    (host_irq)
);

// File: tb/shram_host_port_bench.sv
module shram_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [15:0] ram_addr;
    logic [7:0] ram_wdata, ram_rdata;
    logic       ram_we, ram_re;
    logic       cop_run, cop_irq, bypass, host_irq;
    logic       cop_irq_ack = 1'b0;
    logic [1:0] cop_int = '0;
    logic       hw_int = 1'b0, dma_req = 1'b1;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    shram_host_port u_shram_host_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .ram_rdata(ram_rdata), .cop_run(cop_run), .cop_irq(cop_irq),
        .cop_irq_ack(cop_irq_ack), .cop_int(cop_int), .hw_int(hw_int),
        .dma_req(dma_req), .bypass(bypass), .host_irq(host_irq)
    );

    // bench-side shared RAM model
    logic [7:0] mem [0:65535];
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_addr = a;
        #2 d = host_rdata;
        @(posedge clk); #1;
        host_sel = 1'b0;
    endtask

    // {we, addr[3:0], value}: value is write data or expected read data
    localparam int NV = 18;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {1'b1, 4'h5, 8'h02},  // R1 odd alias of ctrl, R4 step on
        {1'b1, 4'h0, 8'h12},  // R2 high byte
        {1'b1, 4'h3, 8'h34},  // R1 odd alias of low byte
        {1'b0, 4'h1, 8'h12},  // R2 readback high
        {1'b0, 4'h2, 8'h34},  // R2 readback low
        {1'b1, 4'h8, 8'hAA},  // R3 window write
        {1'b1, 4'h9, 8'hBB},  // R3 R1 window at odd alias
        {1'b0, 4'h2, 8'h36},  // R4 two steps
        {1'b1, 4'h2, 8'h34},  // R2 reload low
        {1'b0, 4'h8, 8'hAA},  // R3 window read
        {1'b0, 4'h8, 8'hBB},  // R4 consecutive byte
        {1'b0, 4'h3, 8'h36},  // R4 read also steps
        {1'b1, 4'h6, 8'hFF},  // R10 unmapped write
        {1'b1, 4'hC, 8'h55},  // R10 unmapped write
        {1'b0, 4'h6, 8'h00},  // R10 unmapped read
        {1'b0, 4'hE, 8'h00},  // R10 unmapped read
        {1'b0, 4'h4, 8'h02},  // R10 ctrl untouched
        {1'b0, 4'h0, 8'h12}   // R10 pointer untouched
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        rd(4'h4, r); check("R11 ctrl", r, 8'h00);
        rd(4'h0, r); check("R11 ptr hi", r, 8'h00);
        rd(4'h2, r); check("R11 ptr lo", r, 8'h00);
        check("R11 outputs", {4'h0, cop_run, cop_irq, host_irq, bypass}, 8'h00);

        // table walk (R1 R2 R3 R4 R10)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) wr(VEC[i][11:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][11:8], r);
                check($sformatf("table row %0d", i), r, VEC[i][7:0]);
            end
        end
        check("R3 ram holds AA", mem[16'h1234], 8'hAA);
        check("R3 ram holds BB", mem[16'h1235], 8'hBB);

        // R4 step off: window write leaves pointer
        wr(4'h4, 8'h00);
        wr(4'h2, 8'h40);
        wr(4'h8, 8'h77);
        rd(4'h2, r); check("R4 no step", r, 8'h40);
        check("R3 ram holds 77", mem[16'h1240], 8'h77);

        // R5 wrap
        wr(4'h4, 8'h02);
        wr(4'h0, 8'hFF); wr(4'h2, 8'hFF);
        wr(4'h8, 8'h5A);
        rd(4'h0, r); check("R5 wrap hi", r, 8'h00);
        rd(4'h2, r); check("R5 wrap lo", r, 8'h00);
        check("R5 ram at FFFF", mem[16'hFFFF], 8'h5A);

        // R6 run bit
        wr(4'h4, 8'h04);
        check("R6 run high", {7'h0, cop_run}, 8'h01);
        wr(4'h4, 8'h00);
        check("R6 run low", {7'h0, cop_run}, 8'h00);

        // R7 coprocessor irq
        wr(4'h4, 8'h08);
        check("R7 irq set", {7'h0, cop_irq}, 8'h01);
        wr(4'h4, 8'h00);
        check("R7 zero write keeps", {7'h0, cop_irq}, 8'h01);
        rd(4'h4, r); check("R7 ctrl bit3", r, 8'h08);
        @(negedge clk) cop_irq_ack = 1'b1;
        @(negedge clk) cop_irq_ack = 1'b0;
        check("R7 ack clears", {7'h0, cop_irq}, 8'h00);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 4'h4; host_wdata = 8'h08; cop_irq_ack = 1'b1;
        @(posedge clk); #1;
        host_sel = 1'b0; host_we = 1'b0; cop_irq_ack = 1'b0;
        check("R7 set beats ack", {7'h0, cop_irq}, 8'h01);
        @(negedge clk) cop_irq_ack = 1'b1;
        @(negedge clk) cop_irq_ack = 1'b0;

        // R8 host priority interrupts
        @(negedge clk) cop_int = 2'b10;
        @(negedge clk) cop_int = 2'b00;
        check("R8 host_irq", {7'h0, host_irq}, 8'h01);
        rd(4'h4, r); check("R8 bit5 set", r, 8'h20);
        wr(4'h4, 8'h20);
        rd(4'h4, r); check("R8 w1c", r, 8'h00);
        check("R8 host_irq low", {7'h0, host_irq}, 8'h00);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 4'h4; host_wdata = 8'h10; cop_int = 2'b01;
        @(posedge clk); #1;
        host_sel = 1'b0; host_we = 1'b0; cop_int = 2'b00;
        rd(4'h4, r); check("R8 set beats clear", r, 8'h10);
        wr(4'h4, 8'h10);

        // R9 bypass flags
        hw_int = 1'b1; dma_req = 1'b0;
        wr(4'h4, 8'h01);
        rd(4'h4, r); check("R9 flags in bypass", r, 8'hC1);
        check("R9 bypass port", {7'h0, bypass}, 8'h01);
        hw_int = 1'b0; dma_req = 1'b1;
        rd(4'h4, r); check("R9 flags follow", r, 8'h01);
        hw_int = 1'b1; dma_req = 1'b0;
        wr(4'h4, 8'hC0);
        rd(4'h4, r); check("R9 masked off", r, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule